// File: doc/BRIEF.md
# Sparse Hit Timestamp Buffer for a Binary Pixel

This block sits beside one binary pixel, or one group of pixels, on a sensor that runs at a bunched collider. While a bunch train passes, the block counts beam crossings and looks at a one-bit discriminator decision once per crossing. A crossing with no hit leaves no trace. A crossing with a hit writes its own crossing number into a small local store. A whole train of thousands of crossings therefore costs only one 16-bit word per hit, and the store depth is chosen from the expected hit rate.

The block also gives the comparator its enable. The comparator only needs power for a short moment around each crossing, so the block raises `comp_en` in the same cycle as each crossing strobe that it accepts. When the train ends, the block stops acquiring and drains the store through a valid/ready word stream. The stream opens with a header word that gives the entry count and an overflow flag. The stored crossing numbers follow in ascending order. After the final word has been accepted, the block returns to idle and waits for the next train.

The controller has four named states. IDLE waits for a train start. ACQUIRE counts crossings and records hits. HEADER presents the count and overflow word. DRAIN presents the stored entries. The transitions are:
- IDLE→ACQUIRE on `train_start`.
- ACQUIRE→ACQUIRE (restart) on `train_start`.
- ACQUIRE→HEADER on `train_end`.
- HEADER→IDLE when the header is accepted and the store is empty.
- HEADER→DRAIN when the header is accepted and entries are held.
- DRAIN→IDLE when the last entry is accepted.

Top module: `hit_stamp_buffer`

## Requirements
- R1: After reset the block is in IDLE with `out_valid` low and `comp_en` low.
- R2: `comp_en` is high in exactly those cycles where the block is in ACQUIRE and `xing_strobe` is high, neither `train_start` nor `train_end` is high, and the crossing limit has not been reached. It is combinational, so it lines up with the strobe in the same cycle.
- R3: Crossings are numbered from 0 for the first accepted strobe after a train start, and the number rises by one per accepted strobe. For a hit, the stored word is that number zero-extended to 16 bits, with bits 15:13 equal to zero.
- R4: An accepted strobe with `hit_in` low stores nothing.
- R5: The store holds at most DEPTH entries. Later hits in the same train are dropped and set an overflow flag, which stays set until the next train start.
- R6: At most MAX_XING crossings (numbers 0 to MAX_XING-1, default 5000) are counted per train. Strobes after that raise no `comp_en` and record nothing.
- R7: `train_end` in ACQUIRE leads to HEADER. The first word out is the header: bit 15 is the overflow flag and bits 14:0 are the entry count.
- R8: The entries follow the header in ascending crossing order. `out_last` marks the final word, which is the header itself when the count is zero.
- R9: A word stays on `out_data` unchanged while `out_valid` is high and `out_ready` is low. The stream advances only when both are high. The block is back in IDLE (`out_valid` low) in the cycle after the final word is accepted.
- R10: During HEADER and DRAIN, `hit_in`, `xing_strobe`, `train_start` and `train_end` have no effect, and `comp_en` stays low.
- R11: `train_start` during ACQUIRE restarts the train. It clears the crossing count, the stored entries and the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| train_start | input | 1 | Pulse: begin (or restart) acquisition |
| train_end | input | 1 | Pulse: end acquisition, begin readout |
| xing_strobe | input | 1 | One-cycle strobe per beam crossing |
| hit_in | input | 1 | Discriminator decision, sampled with the strobe |
| comp_en | output | 1 | Comparator enable, aligned with accepted strobes |
| out_valid | output | 1 | Readout word valid |
| out_ready | input | 1 | Receiver accepts the current word |
| out_data | output | 16 | Header word, then the stored crossing numbers |
| out_last | output | 1 | Marks the final word of the readout |

## Verification
On every cycle, the assertions check the following:
- the store never fills past its depth and never shrinks within a train;
- the overflow flag stays set once raised;
- the crossing counter stays within its limit;
- a word that has not been accepted holds still;
- the block goes idle after the last word;
- during readout, no write happens and no comparator enable is raised.

Several behaviours can only be shown by the bench's scenarios against its queue-based model. These are the numbering and content of the stored words, the dropping of hits that arrive when the store is full, the ascending readout order, the empty-train header, the restart in mid-train, and the crossing ceiling at 5000.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACQ,
        ST_HDR,
        ST_DATA
    } hsb_state_t;

    localparam int WORD_W = 16;
endpackage

// File: rtl/hsb_xing_ctr.sv
module hsb_xing_ctr #(
    parameter int MAX_XING = 5000,
    parameter int CW       = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    output logic [CW-1:0] count,
    output logic          at_limit
);
    assign at_limit = (count == CW'(MAX_XING));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (step && !at_limit) begin
            count <= count + CW'(1);
        end
    end

    AST_XING_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(MAX_XING)); // R6
endmodule

// File: rtl/hsb_store.sv
module hsb_store #(
    parameter int DEPTH = 16,
    parameter int XW    = 13,
    parameter int PW    = 5,
    parameter int IW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [XW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [XW-1:0] rd_data,
    output logic [PW-1:0] fill,
    output logic          full
);
    logic [XW-1:0] slots [DEPTH];

    assign full    = (fill == PW'(DEPTH));
    assign rd_data = slots[rd_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill <= '0;
        end else if (clr) begin
            fill <= '0;
        end else if (wr_en && !full) begin
            fill <= fill + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !full && !clr) begin
            slots[fill[IW-1:0]] <= wr_data;
        end
    end

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= PW'(DEPTH)); // R5
    AST_FILL_NO_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> fill >= $past(fill)); // R5
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !clr) |=> full); // R5
endmodule

// File: rtl/hsb_ctrl.sv
module hsb_ctrl
    import hsb_pkg::*;
#(
    parameter int XW = 13,
    parameter int PW = 5,
    parameter int IW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              train_start,
    input  logic              train_end,
    input  logic              xing_strobe,
    input  logic              hit_in,
    input  logic              out_ready,
    input  logic              at_limit,
    input  logic [PW-1:0]     fill,
    input  logic              full,
    input  logic [XW-1:0]     rd_data,
    output logic              clr,
    output logic              ctr_step,
    output logic              st_wr,
    output logic [IW-1:0]     rd_idx,
    output logic              comp_en,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_last
);
    hsb_state_t state, state_nx;
    logic       ovf;
    logic       acq_go;
    logic       accept;
    logic       tail;

    assign clr      = train_start && (state == ST_IDLE || state == ST_ACQ);
    assign acq_go   = (state == ST_ACQ) && !train_start && !train_end
                      && xing_strobe && !at_limit;
    assign ctr_step = acq_go;
    assign st_wr    = acq_go && hit_in;
    assign accept   = out_valid && out_ready;
    assign tail     = (PW'(rd_idx) == fill - PW'(1));

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (train_start) state_nx = ST_ACQ;
            ST_ACQ:  if (!train_start && train_end) state_nx = ST_HDR;
            ST_HDR:  if (accept) state_nx = (fill == '0) ? ST_IDLE : ST_DATA;
            ST_DATA: if (accept && tail) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf    <= 1'b0;
            rd_idx <= '0;
        end else begin
            if (clr) begin
                ovf <= 1'b0;
            end else if (st_wr && full) begin
                ovf <= 1'b1;
            end
            if (state == ST_HDR) begin
                rd_idx <= '0;
            end else if (state == ST_DATA && accept) begin
                rd_idx <= rd_idx + IW'(1);
            end
        end
    end

    always_comb begin
        comp_en   = 1'b0;
        out_valid = 1'b0;
        out_data  = '0;
        out_last  = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_ACQ: comp_en = acq_go;
            ST_HDR: begin
                out_valid    = 1'b1;
                out_data     = WORD_W'(fill);
                out_data[15] = ovf;
                out_last     = (fill == '0);
            end
            ST_DATA: begin
                out_valid = 1'b1;
                out_data  = WORD_W'(rd_data);
                out_last  = tail;
            end
            default: ;
        endcase
    end

    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9
    AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> !out_valid); // R9
    AST_QUIET_COMPARATOR: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !comp_en); // R10
    AST_NO_WRITE_IN_READOUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !st_wr); // R10
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr) |=> ovf); // R5
endmodule

// File: rtl/hit_stamp_buffer.sv
module hit_stamp_buffer
    import hsb_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int MAX_XING = 5000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        train_start,
    input  logic        train_end,
    input  logic        xing_strobe,
    input  logic        hit_in,
    output logic        comp_en,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [15:0] out_data,
    output logic        out_last
);
    localparam int CW = $clog2(MAX_XING + 1);
    localparam int XW = $clog2(MAX_XING);
    localparam int PW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic          clr, ctr_step, st_wr, at_limit, full;
    logic [CW-1:0] count;
    logic [PW-1:0] fill;
    logic [IW-1:0] rd_idx;
    logic [XW-1:0] rd_data;

    hsb_xing_ctr #(.MAX_XING(MAX_XING), .CW(CW)) u_ctr (
        .clk(clk), .rst_n(rst_n), .clr(clr), .step(ctr_step),
        .count(count), .at_limit(at_limit)
    );

    hsb_store #(.DEPTH(DEPTH), .XW(XW), .PW(PW), .IW(IW)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(st_wr),
        .wr_data(count[XW-1:0]), .rd_idx(rd_idx), .rd_data(rd_data),
        .fill(fill), .full(full)
    );

    hsb_ctrl #(.XW(XW), .PW(PW), .IW(IW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .train_start(train_start),
        .train_end(train_end), .xing_strobe(xing_strobe), .hit_in(hit_in),
        .out_ready(out_ready), .at_limit(at_limit), .fill(fill), .full(full),
        .rd_data(rd_data), .clr(clr), .ctr_step(ctr_step), .st_wr(st_wr),
        .rd_idx(rd_idx), .comp_en(comp_en), .out_valid(out_valid),
        .out_data(out_data), .out_last(out_last)
    );
endmodule

// File: tb/hit_stamp_buffer_test.sv
module hit_stamp_buffer_test;
    localparam int DEPTH_T = 6;
    localparam int MAX_T   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        train_start = 0, train_end = 0, xing_strobe = 0, hit_in = 0;
    logic        out_ready = 0;
    logic        comp_en, out_valid, out_last;
    logic [15:0] out_data;

    always #4 clk = ~clk;

    hit_stamp_buffer #(.DEPTH(DEPTH_T), .MAX_XING(MAX_T)) uut (
        .clk(clk), .rst_n(rst_n), .train_start(train_start),
        .train_end(train_end), .xing_strobe(xing_strobe), .hit_in(hit_in),
        .comp_en(comp_en), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cyc      = 0;
    bit    done     = 0;
    string cur_req  = "R1";

    // behavioural reference model: 0 idle, 1 acquire, 2 header, 3 drain
    int m_state = 0;
    int m_xcnt  = 0;
    int m_ridx  = 0;
    bit m_ovf   = 0;
    int m_q[$];

    task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h at cycle %0d", cur_req, what, act, exp, cyc);
        end
    endtask

    task automatic finish_up;
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    always @(negedge clk) begin
        logic        e_comp;
        logic [15:0] e_data;
        logic        e_last;
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_up();
        end
        if (rst_n) begin
            e_comp = (m_state == 1) && xing_strobe && !train_start && !train_end && (m_xcnt < MAX_T);
            chk("comp_en", {15'd0, comp_en}, {15'd0, e_comp});
            chk("out_valid", {15'd0, out_valid}, {15'd0, logic'(m_state >= 2)});
            if (m_state == 2) begin
                e_data = 16'(m_q.size());
                e_data[15] = m_ovf;
                e_last = (m_q.size() == 0);
            end else begin
                e_data = (m_state == 3) ? 16'(m_q[m_ridx]) : 16'd0;
                e_last = (m_state == 3) && (m_ridx == m_q.size() - 1);
            end
            if (m_state >= 2) begin
                chk("out_data", out_data, e_data);
                chk("out_last", {15'd0, out_last}, {15'd0, e_last});
            end
            // advance model with the inputs about to be sampled
            case (m_state)
                0: if (train_start) begin m_state = 1; m_xcnt = 0; m_ovf = 0; m_q.delete(); end
                1: begin
                    if (train_start) begin m_xcnt = 0; m_ovf = 0; m_q.delete(); end
                    else if (train_end) m_state = 2;
                    else if (xing_strobe && m_xcnt < MAX_T) begin
                        if (hit_in) begin
                            if (m_q.size() < DEPTH_T) m_q.push_back(m_xcnt);
                            else m_ovf = 1;
                        end
                        m_xcnt++;
                    end
                end
                2: if (out_ready) begin
                    if (m_q.size() == 0) m_state = 0;
                    else begin m_state = 3; m_ridx = 0; end
                end
                default: if (out_ready) begin
                    if (m_ridx == m_q.size() - 1) m_state = 0;
                    else m_ridx++;
                end
            endcase
        end
    end

    task automatic drv(input logic ts, input logic te, input logic st,
                       input logic ht, input logic rd);
        train_start = ts; train_end = te; xing_strobe = st; hit_in = ht; out_ready = rd;
        @(posedge clk); #1;
    endtask

    task automatic drain(input int mode);
        int k = 0;
        while (m_state != 0) begin
            logic rd;
            case (mode)
                0: rd = 1'b1;
                1: rd = k[0];
                default: rd = (k % 3 == 2);
            endcase
            drv(0, 0, 0, 0, rd);
            k++;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        cur_req = "R1";
        chk("reset out_valid", {15'd0, out_valid}, 16'd0);
        chk("reset comp_en", {15'd0, comp_en}, 16'd0);
        rst_n = 1'b1;
        // R2: strobes while idle give no enable
        cur_req = "R2";
        for (int i = 0; i < 4; i++) drv(0, 0, 1, 1, 0);
        // R3 / R4: sparse hits, strobe every other cycle
        cur_req = "R3";
        drv(1, 0, 0, 0, 0);
        for (int i = 0; i < 20; i++) begin
            drv(0, 0, 1, (i % 7 == 3) || (i == 0), 0);
            drv(0, 0, 0, 1, 0);
        end
        cur_req = "R7";
        drv(0, 1, 1, 1, 0);
        cur_req = "R8";
        drain(0);
        // R9: stalling receiver
        cur_req = "R9";
        drv(1, 0, 0, 0, 0);
        for (int i = 0; i < 12; i++) drv(0, 0, 1, i[1], 0);
        drv(0, 1, 0, 0, 0);
        drain(1);
        // R5: overflow
        cur_req = "R5";
        drv(1, 0, 0, 0, 0);
        for (int i = 0; i < 10; i++) drv(0, 0, 1, 1, 0);
        drv(0, 1, 0, 0, 0);
        drain(2);
        // R7: empty train, header is last
        cur_req = "R7";
        drv(1, 0, 0, 0, 0);
        for (int i = 0; i < 5; i++) drv(0, 0, 1, 0, 0);
        drv(0, 1, 0, 0, 0);
        drain(0);
        // R10: inputs ignored in readout
        cur_req = "R10";
        drv(1, 0, 0, 0, 0);
        drv(0, 0, 1, 1, 0);
        drv(0, 0, 1, 0, 0);
        drv(0, 0, 1, 1, 0);
        drv(0, 1, 0, 0, 0);
        for (int i = 0; i < 4; i++) drv(1, 1, 1, 1, 0);
        drv(0, 0, 0, 0, 1);
        for (int i = 0; i < 3; i++) drv(1, 0, 1, 1, 0);
        drain(0);
        // R11: restart during acquisition
        cur_req = "R11";
        drv(1, 0, 0, 0, 0);
        for (int i = 0; i < 9; i++) drv(0, 0, 1, 1, 0);
        drv(1, 0, 1, 1, 0);
        for (int i = 0; i < 6; i++) drv(0, 0, 1, i[0], 0);
        drv(0, 1, 0, 0, 0);
        drain(0);
        // R6: crossing ceiling
        cur_req = "R6";
        drv(1, 0, 0, 0, 0);
        for (int i = 0; i < MAX_T + 3; i++)
            drv(0, 0, 1, (i == 4997) || (i == 4999) || (i == 5000) || (i == 5002), 0);
        drv(0, 1, 0, 0, 0);
        drain(0);
        drv(0, 0, 0, 0, 0);
        finish_up();
    end
endmodule